// File: doc/BRIEF.md
# Sensor Result I2C Target

This block is an I2C target that lets a host controller read the results of an optical sensor. It runs entirely on a fast system clock. It samples SCL and SDA through synchronizers and finds start and stop conditions and clock edges from the sampled levels. The target never drives a line high. It pulls SDA low through an enable output, and the pad and pull-up outside the block do the rest.

A proximity result and a 12-bit light result arrive on parallel inputs, each with a one-cycle strobe. The block keeps them in a small byte-wide register space, together with two read/write test registers that must stay at zero in normal operation.

To read, the host writes the target address and a register pointer, then sends a stop. It then starts a new transaction with the read bit set and takes data bytes. The pointer advances after every byte, so several registers can be taken in one burst.

Top module: `sens_i2c_target`

## Requirements
- R1: The target answers only the 7-bit address 1000_10s, where s is the level of `addr_strap`, sent MSB first and followed by the R/W bit (1 = read). It acknowledges a match by pulling SDA low during the ninth SCL clock.
- R2: When the address does not match, SDA is never pulled low until the next start, and the transaction has no effect on the register contents.
- R3: In a write transaction, the first byte after the address loads the register pointer and is acknowledged. A later read transaction returns the register at the pointer, 8 bits MSB first, with each bit placed on SDA while SCL is low.
- R4: Register 0x08 holds the 8-bit proximity result. It resets to 0x00 and loads `prox_val` on a cycle with `prox_vld` high. Host writes to it have no effect.
- R5: The 12-bit light result is loaded from `lux_val` on a cycle with `lux_vld` high, and it resets to zero. Register 0x09 returns bits 7:0. Register 0x0A returns bits 11:8 in bits 3:0, and bits 7:4 of 0x0A always read as 0.
- R6: A read of 0x09 latches bits 11:8 of the result as they are at that moment. Register 0x0A returns that latched nibble, so a read of 0x0A after 0x09 matches it even if a new result arrives in between. Before any read of 0x09, 0x0A reads 0x00.
- R7: Registers 0x0E and 0x0F are read/write and reset to 0x00. `test_active` is high exactly while either of them holds a nonzero value.
- R8: The register pointer increments by one after each data byte, whether written or read, so a burst covers consecutive addresses.
- R9: Addresses other than 0x08, 0x09, 0x0A, 0x0E and 0x0F read as 0x00, and writes to them are acknowledged and discarded.
- R10: During a read, the target releases SDA on the acknowledge clock. If the controller does not acknowledge, the target drives nothing more until the next start.
- R11: A stop condition returns the target to idle with SDA released. The target does not drive SDA while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 1 | Least significant bit of the target address |
| prox_val | input | 8 | Proximity conversion result |
| prox_vld | input | 1 | One-cycle strobe that loads `prox_val` |
| lux_val | input | 12 | Light conversion result |
| lux_vld | input | 1 | One-cycle strobe that loads `lux_val` |
| test_active | output | 1 | High while either test register is nonzero |

## Verification
The assertions assume that SCL and SDA are stable for several system clocks between edges. This way the synchronized copies never show a data change and a clock edge in the same cycle. They also assume that SDA changes only while SCL is low, except when a start or stop is framed. The bench drives the bus from tasks that hold each quarter bit for five system clocks and move SDA only with SCL low, and it models the line as a wired AND of the controller and the target. Random result values, register choices and burst lengths come from a fixed seed, together with directed cases for address mismatch, the snapshot ordering, test-register flagging and the not-acknowledged end of a read.

// File: rtl/sens_i2c_pkg.sv
package sens_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_e;

    localparam logic [5:0] TGT_ADDR_HI = 6'b100010;

    localparam logic [7:0] REG_PROX   = 8'h08;
    localparam logic [7:0] REG_LUX_LO = 8'h09;
    localparam logic [7:0] REG_LUX_HI = 8'h0A;
    localparam logic [7:0] REG_TEST_A = 8'h0E;
    localparam logic [7:0] REG_TEST_B = 8'h0F;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t q, n;

    always_comb begin
        n          = q;
        n.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        n.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        n.scl_prev = q.scl_sh[SYNC_STAGES-1];
        n.sda_prev = q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= n;
        end
    end

    assign scl_lvl   = q.scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = q.sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~q.scl_prev;
    assign scl_fall  = ~scl_lvl & q.scl_prev;
    assign start_det = scl_lvl & q.scl_prev & q.sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & q.scl_prev & ~q.sda_prev & sda_lvl;

endmodule

// File: rtl/sens_regfile.sv
module sens_regfile
    import sens_i2c_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PROX_W = 8,
    parameter int LUX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PROX_W-1:0] prox_val,
    input  logic              prox_vld,
    input  logic [LUX_W-1:0]  lux_val,
    input  logic              lux_vld,
    input  logic [7:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              test_active
);

    localparam int HI_W = LUX_W - DW;

    typedef struct packed {
        logic [PROX_W-1:0] prox;
        logic [LUX_W-1:0]  lux;
        logic [HI_W-1:0]   snap;
        logic [DW-1:0]     test_a;
        logic [DW-1:0]     test_b;
    } regs_t;

    regs_t q, n;

    always_comb begin
        n = q;
        if (prox_vld) n.prox = prox_val;
        if (lux_vld)  n.lux  = lux_val;
        if (rd_en && addr == REG_LUX_LO) n.snap = q.lux[LUX_W-1:DW];
        if (wr_en) begin
            case (addr)
                REG_TEST_A: n.test_a = wdata;
                REG_TEST_B: n.test_b = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        case (addr)
            REG_PROX:   rdata = {{(DW-PROX_W){1'b0}}, q.prox};
            REG_LUX_LO: rdata = q.lux[DW-1:0];
            REG_LUX_HI: rdata = {{(DW-HI_W){1'b0}}, q.snap};
            REG_TEST_A: rdata = q.test_a;
            REG_TEST_B: rdata = q.test_b;
            default:    rdata = '0;
        endcase
    end

    assign test_active = (|q.test_a) | (|q.test_b);

    // R7: a nonzero write into a test register raises the flag next cycle
    p_test_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == REG_TEST_A || addr == REG_TEST_B) && wdata != '0)
        |=> test_active);

    // R6: reading the low byte latches the upper nibble present at that moment
    p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_LUX_LO) |=> (q.snap == $past(q.lux[LUX_W-1:DW])));

    // R4: host writes never alter the proximity result
    p_ro_prox_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_PROX && !prox_vld) |=> $stable(q.prox));

    // R5: upper bits of the high light register read as zero
    p_hi_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_LUX_HI) |-> (rdata[DW-1:HI_W] == '0));

endmodule

// File: rtl/sens_i2c_fsm.sv
module sens_i2c_fsm
    import sens_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       strap,
    input  logic [7:0] reg_rdata,
    output logic [7:0] reg_addr,
    output logic       reg_rd_en,
    output logic       reg_wr_en,
    output logic [7:0] reg_wdata,
    output logic       sda_oe
);

    typedef struct packed {
        tgt_state_e  state;
        logic [7:0]  sh;
        logic [3:0]  cnt;
        logic [7:0]  ptr;
        logic        rw;
        logic        first;
        logic        mack;
        logic        oe;
    } fsm_t;

    fsm_t q, n;

    always_comb begin
        n         = q;
        reg_rd_en = 1'b0;
        reg_wr_en = 1'b0;
        if (start_det) begin
            n.state = ST_ADDR;
            n.cnt   = '0;
            n.oe    = 1'b0;
            n.first = 1'b1;
        end else if (stop_det) begin
            n.state = ST_IDLE;
            n.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        n.sh  = {q.sh[6:0], sda_lvl};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.state == ST_ADDR) begin
                            if (q.sh[7:1] == {TGT_ADDR_HI, strap}) begin
                                n.oe    = 1'b1;
                                n.rw    = q.sh[0];
                                n.state = ST_ADDR_ACK;
                            end else begin
                                n.state = ST_WAIT;
                            end
                        end else begin
                            n.oe    = 1'b1;
                            n.state = ST_WR_ACK;
                            n.first = 1'b0;
                            if (q.first) begin
                                n.ptr = q.sh;
                            end else begin
                                reg_wr_en = 1'b1;
                                n.ptr     = q.ptr + 8'd1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            reg_rd_en = 1'b1;
                            n.sh      = reg_rdata;
                            n.oe      = ~reg_rdata[7];
                            n.state   = ST_RD_BYTE;
                        end else begin
                            n.oe    = 1'b0;
                            n.state = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        n.oe    = 1'b0;
                        n.cnt   = '0;
                        n.state = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        n.sh = {q.sh[6:0], 1'b0};
                        if (q.cnt == 4'd7) begin
                            n.oe    = 1'b0;
                            n.cnt   = '0;
                            n.ptr   = q.ptr + 8'd1;
                            n.state = ST_RD_ACK;
                        end else begin
                            n.cnt = q.cnt + 4'd1;
                            n.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            reg_rd_en = 1'b1;
                            n.sh      = reg_rdata;
                            n.oe      = ~reg_rdata[7];
                            n.state   = ST_RD_BYTE;
                        end else begin
                            n.oe    = 1'b0;
                            n.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign reg_addr  = q.ptr;
    assign reg_wdata = q.sh;
    assign sda_oe    = q.oe;

    // R11: idle and waiting states never pull the line
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE || q.state == ST_WAIT) |-> !q.oe);

    // R11: a stop always brings the target back to idle with SDA released
    p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> (q.state == ST_IDLE && !sda_oe));

    // R3: the drive changes only after SCL has fallen or the bus was framed
    p_drive_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall || start_det || stop_det));

    // R10: a missing controller acknowledge ends the data phase
    p_nack_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD_ACK && scl_fall && !q.mack && !start_det && !stop_det)
        |=> (q.state == ST_WAIT && !sda_oe));

endmodule

// File: rtl/sens_i2c_target.sv
module sens_i2c_target #(
    parameter int SYNC_STAGES = 2,
    parameter int PROX_W      = 8,
    parameter int LUX_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_strap,
    input  logic [PROX_W-1:0] prox_val,
    input  logic              prox_vld,
    input  logic [LUX_W-1:0]  lux_val,
    input  logic              lux_vld,
    output logic              test_active
);

    localparam int DW = 8;

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]    reg_addr;
    logic          reg_rd_en, reg_wr_en;
    logic [DW-1:0] reg_wdata, reg_rdata;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sens_i2c_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (addr_strap),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_rd_en (reg_rd_en),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .sda_oe    (sda_oe)
    );

    sens_regfile #(.DW(DW), .PROX_W(PROX_W), .LUX_W(LUX_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .prox_val    (prox_val),
        .prox_vld    (prox_vld),
        .lux_val     (lux_val),
        .lux_vld     (lux_vld),
        .addr        (reg_addr),
        .rd_en       (reg_rd_en),
        .wr_en       (reg_wr_en),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .test_active (test_active)
    );

    // R1: any pull on SDA only happens while SCL is low or was just low
    p_no_pull_unsynced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

endmodule

// File: tb/tb_sens_i2c_target.sv
module tb_sens_i2c_target;

    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        strap = 1'b0;
    logic [7:0]  prox_val = '0;
    logic        prox_vld = 1'b0;
    logic [11:0] lux_val = '0;
    logic        lux_vld = 1'b0;
    logic        test_active;
    logic        sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  prox_m = '0;
    logic [11:0] lux_m = '0;
    logic [3:0]  snap_m = '0;
    logic [7:0]  ta_m = '0;
    logic [7:0]  tb_m = '0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    sens_i2c_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .addr_strap  (strap),
        .prox_val    (prox_val),
        .prox_vld    (prox_vld),
        .lux_val     (lux_val),
        .lux_vld     (lux_vld),
        .test_active (test_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        case (a)
            8'h08: return prox_m;
            8'h09: return lux_m[7:0];
            8'h0A: return {4'h0, snap_m};
            8'h0E: return ta_m;
            8'h0F: return tb_m;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [6:0] tgt_addr();
        return {6'b100010, strap};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic set_prox(input logic [7:0] v);
        @(negedge clk); prox_val = v; prox_vld = 1'b1;
        @(negedge clk); prox_vld = 1'b0;
        prox_m = v;
    endtask

    task automatic set_lux(input logic [11:0] v);
        @(negedge clk); lux_val = v; lux_vld = 1'b1;
        @(negedge clk); lux_vld = 1'b0;
        lux_m = v;
    endtask

    // pointer write, stop, then read burst of n bytes
    task automatic read_seq(input logic [7:0] ptr, input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic [7:0] e;
        bus_start();
        send_byte({tgt_addr(), 1'b0}, ack);
        chk({req, " R1 addr ack"}, ack, 1);
        send_byte(ptr, ack);
        chk({req, " R3 ptr ack"}, ack, 1);
        bus_stop();
        bus_start();
        send_byte({tgt_addr(), 1'b1}, ack);
        chk({req, " R1 read addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = ptr + 8'(i);
            e = exp_byte(a);
            if (a == 8'h09) snap_m = lux_m[11:8];
            recv_byte(i != n - 1, d);
            chk({req, " R8 data"}, d, e);
        end
        chk({req, " R10 released after nack"}, sda_oe, 0);
        bus_stop();
        chk({req, " R11 released after stop"}, sda_oe, 0);
    endtask

    task automatic write_seq(input logic [7:0] ptr, input logic [7:0] d0,
                             input logic [7:0] d1, input int n, input string req);
        logic ack;
        logic [7:0] a;
        bus_start();
        send_byte({tgt_addr(), 1'b0}, ack);
        chk({req, " R1 addr ack"}, ack, 1);
        send_byte(ptr, ack);
        for (int i = 0; i < n; i++) begin
            a = ptr + 8'(i);
            send_byte(i == 0 ? d0 : d1, ack);
            chk({req, " R9 data ack"}, ack, 1);
            if (a == 8'h0E) ta_m = (i == 0) ? d0 : d1;
            if (a == 8'h0F) tb_m = (i == 0) ? d0 : d1;
        end
        bus_stop();
        chk({req, " R7 flag"}, test_active, ((ta_m | tb_m) != 0));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        int   seed;
        seed = $urandom(32'h5EED1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        chk("R11 reset sda_oe", sda_oe, 0);
        chk("R7 reset test_active", test_active, 0);

        // R4 R5 R6 reset contents
        read_seq(8'h08, 3, "R4 R5 R6 reset read");

        // R2 wrong address, wrong strap bit
        strap = 1'b1;
        bus_start();
        send_byte({6'b100010, 1'b0, 1'b1}, ack);
        chk("R2 strap mismatch nack", ack, 0);
        put_bit(1'b1);
        chk("R2 no drive after mismatch", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte({7'h23, 1'b0}, ack);
        chk("R2 other address nack", ack, 0);
        send_byte(8'h0E, ack);
        chk("R2 later byte ignored", ack, 0);
        bus_stop();
        chk("R2 no register effect", test_active, 0);

        // R1 both strap levels
        set_prox(8'hA5);
        read_seq(8'h08, 1, "R1 R3 R4 strap1 prox");
        strap = 1'b0;
        set_prox(8'h3C);
        read_seq(8'h08, 1, "R1 R4 strap0 prox");

        // R5 R8 burst over light result
        set_lux(12'hABC);
        read_seq(8'h09, 2, "R5 R8 lux burst");
        // R6 snapshot holds across an update
        set_lux(12'h123);
        read_seq(8'h0A, 1, "R6 stale snapshot");
        read_seq(8'h09, 1, "R6 new low");
        set_lux(12'hF77);
        read_seq(8'h0A, 1, "R6 consistent high");

        // R7 test registers
        write_seq(8'h0E, 8'h5A, 8'h00, 1, "R7 set A");
        chk("R7 flag high", test_active, 1);
        read_seq(8'h0E, 2, "R7 readback");
        write_seq(8'h0E, 8'h00, 8'h81, 2, "R7 R8 clear A set B");
        write_seq(8'h0F, 8'h00, 8'h00, 1, "R7 clear B");
        chk("R7 flag low", test_active, 0);

        // R9 unimplemented and read-only writes
        write_seq(8'h20, 8'hFF, 8'hEE, 2, "R9 unimpl write");
        read_seq(8'h20, 2, "R9 unimpl read");
        write_seq(8'h08, 8'h99, 8'h77, 2, "R9 R4 ro write");
        read_seq(8'h08, 3, "R9 R4 ro read");

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [7:0] base;
            int kind;
            kind = $urandom_range(0, 4);
            if (kind == 0) set_prox(8'($urandom));
            if (kind == 1) set_lux(12'($urandom));
            case ($urandom_range(0, 5))
                0: base = 8'h08;
                1: base = 8'h09;
                2: base = 8'h0A;
                3: base = 8'h0E;
                4: base = 8'h0F;
                default: base = 8'($urandom);
            endcase
            if (kind == 4)
                write_seq(8'h0E + 8'($urandom_range(0, 1)), 8'($urandom), 8'h00, 1, "R7 random write");
            else
                read_seq(base, $urandom_range(1, 3), "R8 random read");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule